// File: doc/BRIEF.md
# Multicart Program Bank Window Mapper

This block sits on the CPU write path of a cartridge bank controller and translates a 2-bit selector for one of four 8 KB program windows into a ROM bank number. CPU writes land in one of a few registers:
- a target/layout select byte,
- two switchable program bank registers,
- a nametable mirroring bit,
- an unlock control byte,
- an outer game-select register.

The register is chosen by address bits 15, 14, 13 and 0 only. The remaining address bits are not brought into the block at all.

The outer register chooses between two mappings. In per-game mode, the four windows use two switchable banks plus two banks fixed near the top of the ROM. The outer register contributes two high bank bits. In the legacy mode, the four windows together cover one aligned 32 KB block picked by three outer bits. The ROM holds a power-of-two number of 8 KB banks, set by a parameter. The modulo by the bank count is therefore a mask. The bank number is registered, so it appears one clock after the window selector and register state it was computed from.

Top module: `prg_window_mapper`

## Requirements
- R1: While reset is asserted, `bank_out` and `mirror_h` are 0. Reset leaves the select target at 0, layout 0, bank register 0 at 0, bank register 1 at 1, and unlock, outer and mirroring at 0. With those values, window n maps to bank n.
- R2: A write is decoded from {address[15:13], address[0]} alone. The code 100/0 is the select byte, 100/1 is bank data, 101/0 is mirroring, 101/1 is control, and 011/x is the outer register. Aliased addresses such as 0x9FFE, 0x9FFF and 0xBFFE behave like 0x8000, 0x8001 and 0xA000.
- R3: A bank-data write loads bank register 0 when the select target (select byte bits 2:0) is 6. It loads bank register 1 when the target is 7. Any other target leaves both program bank registers unchanged.
- R4: A write to the outer register takes effect only while bit 7 of the last control byte is 1. Otherwise the write is ignored.
- R5: With outer bit 0 = 1 and layout (select byte bit 6) = 0, windows 0..3 give bank register 0, bank register 1, the second-last bank and the last bank.
- R6: With outer bit 0 = 1 and layout = 1, windows 0 and 2 exchange their sources. Window 1 and window 3 are unchanged.
- R7: In per-game mode, each bank number is {outer[7:6], low 4 bits of its source}. The fixed sources are the low 4 bits of (bank count − 1), with bit 0 cleared for the second-last bank.
- R8: With outer bit 0 = 0, window n maps to bank {outer[6:4], n}.
- R9: Every bank number is reduced modulo the bank count 2^BANK_LOG2. Bits above BANK_LOG2−1 of `bank_out` are 0.
- R10: A mirroring write sets `mirror_h` to data bit 0 (1 = horizontal, 0 = vertical) on the clock of the write. The write is ignored while `four_screen` is 1.
- R11: `bank_out` shows the bank for the `win_sel` value and register state present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | CPU write strobe, one write per high cycle |
| cpu_a_hi | input | 3 | CPU address bits 15:13 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| cpu_data | input | 8 | CPU write data |
| four_screen | input | 1 | Cartridge has fixed four-screen nametables; mirroring writes ignored |
| win_sel | input | 2 | Addressed 8 KB program window (CPU address bits 14:13) |
| bank_out | output | 6 | Registered 8 KB bank number for the selected window |
| mirror_h | output | 1 | Mirroring select: 1 horizontal, 0 vertical |

## Verification
A corrupted bank register, layout bit or outer field does not stay hidden. It changes `bank_out` on the clock after `win_sel` points at an affected window. Sweeping all four windows every few cycles therefore exposes it within about four clocks. A wrong fixed-bank constant or mask shows only on windows 2 and 3, or only when outer bits 7:6 are non-zero. For this reason the stimulus sets high outer bits with a bank count smaller than 64. A mirroring or unlock bit that ignores its gating shows on `mirror_h` at once, or on the next window sweep after an outer write.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;

  // Kinds of decoded CPU writes
  typedef enum logic [2:0] {
    K_NONE,
    K_SELECT,
    K_BANKDATA,
    K_MIRROR,
    K_CTRL,
    K_OUTER
  } wr_kind_e;

  // Outer game-select fields that the mapping actually uses
  typedef struct packed {
    logic [1:0] hi;        // high bank bits in per-game mode
    logic [2:0] blk;       // 32 KB block number in legacy mode
    logic       game_mode; // 1: per-game 8 KB switching
  } outer_t;

  localparam int PRG_W  = 4;  // stored width of inner bank values
  localparam int FULL_W = 6;  // widest bank number the fields can form
  localparam int TGT_W  = 3;

  localparam logic [TGT_W-1:0] TGT_PRG0 = 3'd6;
  localparam logic [TGT_W-1:0] TGT_PRG1 = 3'd7;

  localparam int LAYOUT_BIT = 6;
  localparam int UNLOCK_BIT = 7;

endpackage

// File: rtl/prg_rst_sync.sv
module prg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];

endmodule

// File: rtl/prg_wr_decode.sv
module prg_wr_decode
  import prg_map_pkg::*;
(
  input  logic       wr_en,
  input  logic [2:0] a_hi,
  input  logic       a0,
  output wr_kind_e   kind
);

  always_comb begin
    kind = K_NONE;
    if (wr_en) begin
      case (a_hi)
        3'b100:  kind = a0 ? K_BANKDATA : K_SELECT;
        3'b101:  kind = a0 ? K_CTRL     : K_MIRROR;
        3'b011:  kind = K_OUTER;
        default: kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/prg_map_regs.sv
module prg_map_regs
  import prg_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_s,
  input  wr_kind_e         kind,
  input  logic [7:0]       data,
  input  logic             four_screen,
  output logic [TGT_W-1:0] sel_tgt_q,
  output logic             layout_q,
  output logic [PRG_W-1:0] prg0_q,
  output logic [PRG_W-1:0] prg1_q,
  output logic             unlock_q,
  output outer_t           outer_q,
  output logic             mirror_q
);

  logic [TGT_W-1:0] sel_tgt_d;
  logic             layout_d;
  logic [PRG_W-1:0] prg0_d;
  logic [PRG_W-1:0] prg1_d;
  logic             unlock_d;
  outer_t           outer_d;
  logic             mirror_d;

  // next-state
  always_comb begin
    sel_tgt_d = sel_tgt_q;
    layout_d  = layout_q;
    prg0_d    = prg0_q;
    prg1_d    = prg1_q;
    unlock_d  = unlock_q;
    outer_d   = outer_q;
    mirror_d  = mirror_q;
    case (kind)
      K_SELECT: begin
        sel_tgt_d = data[TGT_W-1:0];
        layout_d  = data[LAYOUT_BIT];
      end
      K_BANKDATA: begin
        if (sel_tgt_q == TGT_PRG0)      prg0_d = data[PRG_W-1:0];
        else if (sel_tgt_q == TGT_PRG1) prg1_d = data[PRG_W-1:0];
      end
      K_MIRROR: begin
        if (!four_screen) mirror_d = data[0];
      end
      K_CTRL: begin
        unlock_d = data[UNLOCK_BIT];
      end
      K_OUTER: begin
        if (unlock_q) begin
          outer_d.hi        = data[7:6];
          outer_d.blk       = data[6:4];
          outer_d.game_mode = data[0];
        end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_tgt_q <= '0;
      layout_q  <= 1'b0;
      prg0_q    <= PRG_W'(0);
      prg1_q    <= PRG_W'(1);
      unlock_q  <= 1'b0;
      outer_q   <= '0;
      mirror_q  <= 1'b0;
    end else begin
      sel_tgt_q <= sel_tgt_d;
      layout_q  <= layout_d;
      prg0_q    <= prg0_d;
      prg1_q    <= prg1_d;
      unlock_q  <= unlock_d;
      outer_q   <= outer_d;
      mirror_q  <= mirror_d;
    end
  end

endmodule

// File: rtl/prg_bank_calc.sv
module prg_bank_calc
  import prg_map_pkg::*;
#(
  parameter int BANK_LOG2 = 5
) (
  input  outer_t            outer,
  input  logic              layout,
  input  logic [PRG_W-1:0]  prg0,
  input  logic [PRG_W-1:0]  prg1,
  input  logic [1:0]        win,
  output logic [FULL_W-1:0] bank
);

  localparam int TOTAL = 1 << BANK_LOG2;
  localparam logic [FULL_W-1:0] LAST_IDX  = FULL_W'(TOTAL - 1);
  localparam logic [FULL_W-1:0] BANK_MASK = LAST_IDX;
  localparam logic [PRG_W-1:0]  LAST_LO   = LAST_IDX[PRG_W-1:0];
  localparam logic [PRG_W-1:0]  PENULT_LO = {LAST_IDX[PRG_W-1:1], 1'b0};

  logic [PRG_W-1:0]  game_lo  [4];
  logic [FULL_W-1:0] win_bank [4];

  // per-game sources; layout swaps windows 0 and 2
  assign game_lo[0] = layout ? PENULT_LO : prg0;
  assign game_lo[1] = prg1;
  assign game_lo[2] = layout ? prg0 : PENULT_LO;
  assign game_lo[3] = LAST_LO;

  for (genvar w = 0; w < 4; w++) begin : g_win
    assign win_bank[w] = (outer.game_mode ? {outer.hi, game_lo[w]}
                                          : {outer.blk, 2'(w)}) & BANK_MASK;
  end

  assign bank = win_bank[win];

endmodule

// File: rtl/prg_window_mapper.sv
module prg_window_mapper
  import prg_map_pkg::*;
#(
  parameter int BANK_LOG2   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_a_hi,
  input  logic              cpu_a0,
  input  logic [7:0]        cpu_data,
  input  logic              four_screen,
  input  logic [1:0]        win_sel,
  output logic [FULL_W-1:0] bank_out,
  output logic              mirror_h
);

  logic              rst_s;
  wr_kind_e          kind;
  logic [TGT_W-1:0]  sel_tgt_q;
  logic              layout_q;
  logic [PRG_W-1:0]  prg0_q;
  logic [PRG_W-1:0]  prg1_q;
  logic              unlock_q;
  outer_t            outer_q;
  logic              mirror_q;
  logic [FULL_W-1:0] bank_d;
  logic [FULL_W-1:0] bank_q;

  prg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  prg_wr_decode u_dec (
    .wr_en (cpu_wr),
    .a_hi  (cpu_a_hi),
    .a0    (cpu_a0),
    .kind  (kind)
  );

  prg_map_regs u_regs (
    .clk         (clk),
    .rst_s       (rst_s),
    .kind        (kind),
    .data        (cpu_data),
    .four_screen (four_screen),
    .sel_tgt_q   (sel_tgt_q),
    .layout_q    (layout_q),
    .prg0_q      (prg0_q),
    .prg1_q      (prg1_q),
    .unlock_q    (unlock_q),
    .outer_q     (outer_q),
    .mirror_q    (mirror_q)
  );

  prg_bank_calc #(.BANK_LOG2(BANK_LOG2)) u_calc (
    .outer  (outer_q),
    .layout (layout_q),
    .prg0   (prg0_q),
    .prg1   (prg1_q),
    .win    (win_sel),
    .bank   (bank_d)
  );

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank_out = bank_q;
  assign mirror_h = mirror_q;

endmodule

// File: rtl/prg_window_mapper_chk.sv
module prg_window_mapper_chk
  import prg_map_pkg::*;
#(
  parameter int BANK_LOG2 = 5
) (
  input logic              clk,
  input logic              rst_s,
  input wr_kind_e          kind,
  input logic [TGT_W-1:0]  sel_tgt_q,
  input logic              unlock_q,
  input outer_t            outer_q,
  input logic [PRG_W-1:0]  prg0_q,
  input logic [PRG_W-1:0]  prg1_q,
  input logic              four_screen,
  input logic [1:0]        win_sel,
  input logic [FULL_W-1:0] bank_out,
  input logic              mirror_h
);

  localparam int TOTAL   = 1 << BANK_LOG2;
  localparam int LAST_LO = (TOTAL - 1) & 15;

  // R3: non-program targets leave both bank registers alone
  p_other_target_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (kind == K_BANKDATA && sel_tgt_q != TGT_PRG0 && sel_tgt_q != TGT_PRG1)
    |=> ($stable(prg0_q) && $stable(prg1_q)));

  // R4: locked outer register ignores writes
  p_outer_locked_r4: assert property (@(posedge clk) disable iff (!rst_s)
    (kind == K_OUTER && !unlock_q) |=> $stable(outer_q));

  // R10: four-screen freezes mirroring
  p_mirror_fixed_r10: assert property (@(posedge clk) disable iff (!rst_s)
    four_screen |=> $stable(mirror_h));

  // R8: legacy mode puts the window number in the low bank bits
  p_legacy_window_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !outer_q.game_mode |=> (bank_out[1:0] == $past(win_sel)));

  // R5: last window fixed to the top bank in per-game mode
  p_last_fixed_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (outer_q.game_mode && win_sel == 2'd3)
    |=> ((32'(bank_out) & 32'hF) == 32'(LAST_LO)));

  // R9: no bank at or above the bank count
  p_bank_range_r9: assert property (@(posedge clk) disable iff (!rst_s)
    1'b1 |=> (32'(bank_out) < TOTAL));

endmodule

bind prg_window_mapper prg_window_mapper_chk #(.BANK_LOG2(BANK_LOG2)) u_chk (
  .clk         (clk),
  .rst_s       (rst_s),
  .kind        (kind),
  .sel_tgt_q   (sel_tgt_q),
  .unlock_q    (unlock_q),
  .outer_q     (outer_q),
  .prg0_q      (prg0_q),
  .prg1_q      (prg1_q),
  .four_screen (four_screen),
  .win_sel     (win_sel),
  .bank_out    (bank_out),
  .mirror_h    (mirror_h)
);

// File: tb/tb_prg_window_mapper.sv
`timescale 1ns/1ps
module tb_prg_window_mapper;

  localparam int BANK_LOG2 = 5;
  localparam int TOTAL     = 1 << BANK_LOG2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_wr;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        four_screen;
  logic [1:0]  win_sel;
  logic [5:0]  bank_out;
  logic        mirror_h;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  prg_window_mapper #(.BANK_LOG2(BANK_LOG2)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_wr      (cpu_wr),
    .cpu_a_hi    (cpu_addr[15:13]),
    .cpu_a0      (cpu_addr[0]),
    .cpu_data    (cpu_data),
    .four_screen (four_screen),
    .win_sel     (win_sel),
    .bank_out    (bank_out),
    .mirror_h    (mirror_h)
  );

  // ---------------- behavioural reference ----------------
  int m_sel, m_prg0, m_prg1, m_ctrl, m_outer, m_mir;
  int exp_bank, exp_mir, live;

  function automatic int ref_bank(int w);
    int hi, pen, last, b;
    if (m_outer % 2 == 1) begin
      hi   = ((m_outer / 64) % 4) * 16;
      pen  = (((TOTAL - 1) % 16) / 2) * 2 + hi;
      last = ((TOTAL - 1) % 16) + hi;
      case (w)
        0: b = ((m_sel / 64) % 2 == 1) ? pen : (m_prg0 % 16) + hi;
        1: b = (m_prg1 % 16) + hi;
        2: b = ((m_sel / 64) % 2 == 1) ? (m_prg0 % 16) + hi : pen;
        default: b = last;
      endcase
    end else begin
      b = ((m_outer / 16) % 8) * 4 + w;
    end
    return b % TOTAL;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_prg0 = 0; m_prg1 = 1; m_ctrl = 0; m_outer = 0; m_mir = 0;
      live = 0;
    end else begin
      exp_bank = ref_bank(int'(win_sel));
      if (cpu_wr) begin
        case (cpu_addr[15:13])
          3'b100: if (!cpu_addr[0]) m_sel = cpu_data;
                  else if (m_sel % 8 == 6) m_prg0 = cpu_data;
                  else if (m_sel % 8 == 7) m_prg1 = cpu_data;
          3'b101: if (cpu_addr[0]) m_ctrl = cpu_data;
                  else if (!four_screen) m_mir = cpu_data % 2;
          3'b011: if (m_ctrl >= 128) m_outer = cpu_data;
          default: ;
        endcase
      end
      exp_mir = m_mir;
      live++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && live >= 4 && !done) begin
      checks++;
      if (int'(bank_out) != exp_bank) begin
        fails++;
        $display("FAIL %s bank actual=%0d expected=%0d",
                 (m_outer % 2 == 0) ? "R8" : ((m_sel / 64) % 2 == 1 ? "R6" : "R5"),
                 bank_out, exp_bank);
      end
      checks++;
      if (int'(mirror_h) != exp_mir) begin
        fails++;
        $display("FAIL R10 mirror actual=%0d expected=%0d", mirror_h, exp_mir);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    tick();
    cpu_wr = 1'b0;
  endtask

  task automatic peek(logic [1:0] w, int exp, string tag);
    win_sel = w;
    tick();
    check(tag, int'(bank_out), exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_data = '0;
    four_screen = 1'b0; win_sel = 2'd0;
    repeat (3) tick();
    check("R1 reset bank", int'(bank_out), 0);
    check("R1 reset mirror", int'(mirror_h), 0);
    rst_n = 1'b1;
    repeat (5) tick();

    // R1: reset state maps window n to bank n
    peek(2'd0, 0, "R1");
    peek(2'd3, 3, "R1");

    // unlock and enter per-game mode with outer bits 7:6 = 3
    wr(16'hA001, 8'h80);
    wr(16'h6000, 8'hC1);
    wr(16'h8000, 8'h06);
    wr(16'h8001, 8'h2A);
    wr(16'h8000, 8'h07);
    wr(16'h8001, 8'h05);
    peek(2'd0, 8'h1A, "R5");
    peek(2'd1, 8'h15, "R7");
    peek(2'd2, 8'h1E, "R5");
    peek(2'd3, 8'h1F, "R9");

    // R6: layout swaps windows 0 and 2
    wr(16'h8000, 8'h46);
    peek(2'd0, 8'h1E, "R6");
    peek(2'd2, 8'h1A, "R6");
    peek(2'd3, 8'h1F, "R6");

    // R3: target 2 does not touch program banks
    wr(16'h8000, 8'h42);
    wr(16'h8001, 8'hFF);
    peek(2'd2, 8'h1A, "R3");
    peek(2'd1, 8'h15, "R3");

    // R2: aliased addresses
    wr(16'h9FFE, 8'h07);
    wr(16'h9FFF, 8'h09);
    peek(2'd1, 8'h19, "R2");
    peek(2'd0, 8'h1A, "R2");

    // R10: mirroring and the four-screen lock
    wr(16'hA000, 8'h01);
    check("R10 set", int'(mirror_h), 1);
    wr(16'hBFFE, 8'h00);
    check("R2 alias mirror", int'(mirror_h), 0);
    four_screen = 1'b1;
    wr(16'hA000, 8'h01);
    check("R10 locked", int'(mirror_h), 0);
    four_screen = 1'b0;

    // R4: locked outer write has no effect
    wr(16'hA001, 8'h00);
    wr(16'h6000, 8'h70);
    peek(2'd0, 8'h1A, "R4");

    // R8: legacy 32 KB block
    wr(16'hA001, 8'h80);
    wr(16'h7FFF, 8'h70);
    peek(2'd0, 28, "R8");
    peek(2'd3, 31, "R8");
    peek(2'd1, 29, "R8");

    // R11: output follows the selector one clock later
    win_sel = 2'd2;
    check("R11 before edge", int'(bank_out), 29);
    tick();
    check("R11 after edge", int'(bank_out), 30);

    // mixed traffic checked by the reference model every clock
    for (int i = 0; i < 4000; i++) begin
      win_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) four_screen = ~four_screen;
      if ($urandom_range(0, 2) == 0) begin
        cpu_wr = 1'b1;
        case ($urandom_range(0, 6))
          0: cpu_addr = 16'h8000;
          1: cpu_addr = 16'h8001;
          2: cpu_addr = 16'hA000;
          3: cpu_addr = 16'hA001;
          4: cpu_addr = 16'h6000;
          5: cpu_addr = 16'h9FFF;
          default: cpu_addr = 16'($urandom);
        endcase
        cpu_data = 8'($urandom);
      end else begin
        cpu_wr = 1'b0;
      end
      tick();
    end
    cpu_wr = 1'b0;
    tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule